// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block drains transmit frames that software has queued in a ring of two-word descriptors. Each descriptor holds a byte address for its buffer in the first word and a control word in the second. Software hands a descriptor to the hardware by clearing its ownership flag, then pulses a start command. The reader walks the ring from the current slot. It fetches each buffer's bytes out of a word-wide dual-port memory model and presents them one at a time on a valid/ready byte stream toward a MAC. It then writes the control word back with the ownership flag set, so software can see the slot is free.

A frame may span several descriptors. Only the last one carries the end-of-frame flag, and that descriptor's final byte is tagged as the last byte on the stream. A descriptor may also ask the MAC to leave out the frame check sequence. The reader returns to the ring base after the descriptor that carries the wrap flag. It stops on its own when it meets a descriptor still owned by hardware. A halt command lets the frame in progress finish and then stops the reader. Error conditions reported by the MAC, and a frame that runs out of descriptors before its end, are recorded in status bits of the written-back control words. After reset the block sweeps the ring and marks every slot as done, and it marks the last slot with the wrap flag.

The memory's second port belongs to software: it fills buffers and descriptors and reads back the written-back control words through it.

Top module: `tx_desc_dma`

## Requirements
- R1: For RING_ENTRIES cycles after reset the block writes the control word (address ring_base + 2*i + 1) of every descriptor i to 0x80000000, and the final one to 0xC0000000. During this sweep busy and tx_valid stay low.
- R2: busy rises after a start_cmd pulse and stays high while the reader fetches and sends. It falls when the reader stops, and tx_valid is low whenever busy is low.
- R3: A descriptor's buffer starts at the byte address held in bits [MEM_AW+1:0] of its first word (ring_base + 2*i). Its length in bytes is in control bits 10:0. Byte address b sits in memory word b>>2, in bits 8*(b%4)+7 : 8*(b%4). These bytes go out in increasing address order, and a byte on tx_data stays stable until tx_valid and tx_ready are both high.
- R4: Control bit 15 marks the last descriptor of a frame. tx_last is high only with the final byte of such a descriptor, so a frame spread over several descriptors shows tx_last exactly once.
- R5: When control bit 16 is set, tx_nocrc is high with every byte of that descriptor; otherwise it is low.
- R6: Each descriptor that has been sent has its control word written back unchanged, except that bit 31 (used) is set. The write happens only after the final byte of that descriptor has been accepted, so the word shows bit 31 clear while that byte is still waiting on tx_ready.
- R7: After a descriptor with control bit 30 (wrap), the next descriptor fetched is the one at ring_base; otherwise the next slot follows.
- R8: When not inside a frame, a descriptor whose bit 31 is already set stops the reader. Nothing is sent, busy falls, and that descriptor is left unchanged. The next start resumes at the same slot.
- R9: Inside a frame, a descriptor found with bit 31 set gets bit 27 set in its control word, and the reader stops.
- R10: A mac_underrun pulse during a frame sets bit 28, and a mac_retry_limit pulse sets bit 29, in the written-back control words of that frame from the pulse onward. Both flags clear at the start of the next frame.
- R11: A halt_cmd pulse while busy lets the current frame finish and then stops the reader. The next descriptor stays with bit 31 clear and is not sent until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cmd | input | 1 | One-cycle pulse to begin walking the ring |
| halt_cmd | input | 1 | One-cycle pulse to stop after the current frame |
| ring_base | input | MEM_AW | Word address of descriptor 0 |
| busy | output | 1 | Reader active |
| host_we | input | 1 | Software write enable to the memory model |
| host_addr | input | MEM_AW | Software word address |
| host_wdata | input | 32 | Software write data |
| host_rdata | output | 32 | Software read data, one cycle after the address |
| tx_valid | output | 1 | Byte available on the stream |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_nocrc | output | 1 | MAC should not append a check sequence |
| tx_ready | input | 1 | MAC accepts the byte |
| mac_underrun | input | 1 | MAC reports an underrun in the current frame |
| mac_retry_limit | input | 1 | MAC reports that its retry limit was exceeded |

## Verification
Single-descriptor frames are sent with a table of buffer addresses that start on every byte lane, with lengths from one byte to several words, with the check-sequence flag in both states, and under an always-ready sink and a slow sink. This separates lane selection, word-crossing and handshake-stall faults. Frames that span two descriptors, frames that run past the wrap slot, and a sink held off while the control word is read show whether tx_last, ring wrap and the timing of the write-back are right. Directed runs cover the empty ring after reset, a frame that runs out of descriptors, MAC error pulses in two frames one after the other (showing that the flags clear), and a halt issued in the middle of a frame followed by a restart.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int LEN_W   = 11;
  localparam int B_EOF   = 15;
  localparam int B_NOCRC = 16;
  localparam int B_EXH   = 27;
  localparam int B_UND   = 28;
  localparam int B_RTY   = 29;
  localparam int B_WRAP  = 30;
  localparam int B_USED  = 31;

  typedef enum logic [3:0] {
    ST_INIT, ST_IDLE, ST_RDC, ST_CHK, ST_PTR, ST_SEND, ST_WB, ST_EXH, ST_STOP
  } tdr_state_e;
endpackage

// File: rtl/tx_ring_mem.sv
module tx_ring_mem #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/tx_desc_ctrl.sv
module tx_desc_ctrl
  import tdr_pkg::*;
#(
  parameter int MEM_AW       = 8,
  parameter int RING_ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_cmd,
  input  logic              halt_cmd,
  input  logic [MEM_AW-1:0] ring_base,
  output logic              busy,
  output logic              m_we,
  output logic [MEM_AW-1:0] m_addr,
  output logic [31:0]       m_wdata,
  input  logic [31:0]       m_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              tx_nocrc,
  input  logic              tx_ready,
  input  logic              mac_underrun,
  input  logic              mac_retry_limit
);
  localparam int IW = MEM_AW - 1;
  localparam int BW = MEM_AW + 2;
  localparam logic [IW-1:0] LAST_IDX = IW'(RING_ENTRIES - 1);

  tdr_state_e       state;
  logic [IW-1:0]    idx;
  logic [IW-1:0]    icnt;
  logic [31:0]      ctrl_q;
  logic [BW-1:0]    bptr;
  logic [LEN_W-1:0] remaining;
  logic [31:0]      wbuf;
  logic             word_ok;
  logic             fetch_pend;
  logic             in_frame;
  logic             start_pend;
  logic             halt_pend;
  logic             err_und;
  logic             err_rty;

  logic [MEM_AW-1:0] desc_addr;
  logic [MEM_AW-1:0] ctl_addr;
  logic              out_free;
  logic              need_fetch;
  logic [31:0]       wb_word;

  assign desc_addr  = ring_base + {idx, 1'b0};
  assign ctl_addr   = ring_base + {idx, 1'b1};
  assign out_free   = !tx_valid || tx_ready;
  assign need_fetch = (state == ST_SEND) && !word_ok && !fetch_pend && (remaining != '0);

  always_comb begin
    wb_word = ctrl_q;
    wb_word[B_USED] = 1'b1;
    wb_word[B_UND]  = ctrl_q[B_UND] | err_und | mac_underrun;
    wb_word[B_RTY]  = ctrl_q[B_RTY] | err_rty | mac_retry_limit;
  end

  // memory port: one access per cycle, chosen by state
  always_comb begin
    m_we    = 1'b0;
    m_addr  = ctl_addr;
    m_wdata = '0;
    case (state)
      ST_INIT: begin
        m_we    = 1'b1;
        m_addr  = ring_base + {icnt, 1'b1};
        m_wdata = '0;
        m_wdata[B_USED] = 1'b1;
        m_wdata[B_WRAP] = (icnt == LAST_IDX);
      end
      ST_CHK:  m_addr = desc_addr;
      ST_SEND: m_addr = bptr[BW-1:2];
      ST_WB: begin
        m_we    = 1'b1;
        m_wdata = wb_word;
      end
      ST_EXH: begin
        m_we    = 1'b1;
        m_wdata = ctrl_q;
        m_wdata[B_EXH] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_INIT;
      idx        <= '0;
      icnt       <= '0;
      ctrl_q     <= '0;
      bptr       <= '0;
      remaining  <= '0;
      wbuf       <= '0;
      word_ok    <= 1'b0;
      fetch_pend <= 1'b0;
      in_frame   <= 1'b0;
      start_pend <= 1'b0;
      halt_pend  <= 1'b0;
      err_und    <= 1'b0;
      err_rty    <= 1'b0;
      busy       <= 1'b0;
      tx_valid   <= 1'b0;
      tx_data    <= '0;
      tx_last    <= 1'b0;
      tx_nocrc   <= 1'b0;
    end else begin
      if (start_cmd) start_pend <= 1'b1;
      else if (state == ST_IDLE && start_pend) start_pend <= 1'b0;

      if (halt_cmd && busy) halt_pend <= 1'b1;

      if (state != ST_IDLE && state != ST_INIT) begin
        if (mac_underrun)    err_und <= 1'b1;
        if (mac_retry_limit) err_rty <= 1'b1;
      end

      case (state)
        ST_INIT: begin
          icnt <= icnt + 1'b1;
          if (icnt == LAST_IDX) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (start_pend) begin
            busy  <= 1'b1;
            state <= ST_RDC;
          end
        end
        ST_RDC: begin
          if (halt_pend && !in_frame) state <= ST_STOP;
          else                        state <= ST_CHK;
        end
        ST_CHK: begin
          ctrl_q <= m_rdata;
          if (m_rdata[B_USED]) begin
            state <= in_frame ? ST_EXH : ST_STOP;
          end else begin
            if (!in_frame) begin
              err_und <= mac_underrun;
              err_rty <= mac_retry_limit;
            end
            state <= ST_PTR;
          end
        end
        ST_PTR: begin
          bptr       <= m_rdata[BW-1:0];
          remaining  <= ctrl_q[LEN_W-1:0];
          word_ok    <= 1'b0;
          fetch_pend <= 1'b0;
          state      <= ST_SEND;
        end
        ST_SEND: begin
          if (need_fetch) fetch_pend <= 1'b1;
          if (fetch_pend) begin
            wbuf       <= m_rdata;
            word_ok    <= 1'b1;
            fetch_pend <= 1'b0;
          end
          if (out_free) begin
            if (remaining != '0 && word_ok) begin
              tx_valid  <= 1'b1;
              tx_data   <= wbuf[{bptr[1:0], 3'b000} +: 8];
              tx_last   <= (remaining == LEN_W'(1)) && ctrl_q[B_EOF];
              tx_nocrc  <= ctrl_q[B_NOCRC];
              bptr      <= bptr + 1'b1;
              remaining <= remaining - 1'b1;
              if (bptr[1:0] == 2'd3) word_ok <= 1'b0;
            end else begin
              tx_valid <= 1'b0;
              tx_last  <= 1'b0;
              if (remaining == '0) state <= ST_WB;
            end
          end
        end
        ST_WB: begin
          in_frame <= !ctrl_q[B_EOF];
          idx      <= ctrl_q[B_WRAP] ? '0 : idx + 1'b1;
          state    <= ST_RDC;
        end
        ST_EXH: begin
          in_frame <= 1'b0;
          state    <= ST_STOP;
        end
        ST_STOP: begin
          busy      <= 1'b0;
          halt_pend <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: nothing leaves the block while the ring is being swept
  a_r1_init_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INIT) |-> (!busy && !tx_valid));

  // R2: an idle reader never drives the stream
  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tx_valid);

  // R3: a stalled byte is held unchanged
  a_r3_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_nocrc)));

  // R4: end marker only accompanies a valid byte
  a_r4_last_valid: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  // R6: write-back only once the stream has drained
  a_r6_wb_drained: assert property (@(posedge clk) disable iff (rst)
    (m_we && state == ST_WB) |-> !tx_valid);

  // R7: wrap flag returns the reader to slot zero
  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB && ctrl_q[B_WRAP]) |=> (idx == '0));
endmodule

// File: rtl/tx_desc_dma.sv
module tx_desc_dma #(
  parameter int MEM_AW       = 8,
  parameter int RING_ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_cmd,
  input  logic              halt_cmd,
  input  logic [MEM_AW-1:0] ring_base,
  output logic              busy,
  input  logic              host_we,
  input  logic [MEM_AW-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              tx_nocrc,
  input  logic              tx_ready,
  input  logic              mac_underrun,
  input  logic              mac_retry_limit
);
  logic              m_we;
  logic [MEM_AW-1:0] m_addr;
  logic [31:0]       m_wdata;
  logic [31:0]       m_rdata;

  tx_ring_mem #(.AW(MEM_AW), .DW(32)) u_mem (
    .clk     (clk),
    .a_we    (host_we),
    .a_addr  (host_addr),
    .a_wdata (host_wdata),
    .a_rdata (host_rdata),
    .b_we    (m_we),
    .b_addr  (m_addr),
    .b_wdata (m_wdata),
    .b_rdata (m_rdata)
  );

  tx_desc_ctrl #(.MEM_AW(MEM_AW), .RING_ENTRIES(RING_ENTRIES)) u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .start_cmd       (start_cmd),
    .halt_cmd        (halt_cmd),
    .ring_base       (ring_base),
    .busy            (busy),
    .m_we            (m_we),
    .m_addr          (m_addr),
    .m_wdata         (m_wdata),
    .m_rdata         (m_rdata),
    .tx_valid        (tx_valid),
    .tx_data         (tx_data),
    .tx_last         (tx_last),
    .tx_nocrc        (tx_nocrc),
    .tx_ready        (tx_ready),
    .mac_underrun    (mac_underrun),
    .mac_retry_limit (mac_retry_limit)
  );
endmodule

// File: tb/tb_tx_desc_dma.sv
module tb_tx_desc_dma;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW = 8;
  localparam int RING = 4;
  localparam int BASE = 8;
  // vector: byte address [23:12], length [11:1], no-check-sequence [0]
  localparam logic [23:0] VEC [0:5] = '{
    {12'd128, 11'd1,  1'b0},
    {12'd130, 11'd5,  1'b1},
    {12'd257, 11'd8,  1'b0},
    {12'd515, 11'd13, 1'b0},
    {12'd600, 11'd4,  1'b1},
    {12'd701, 11'd20, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_cmd = 1'b0, halt_cmd = 1'b0;
  logic [MEM_AW-1:0] ring_base = MEM_AW'(BASE);
  logic busy;
  logic host_we = 1'b0;
  logic [MEM_AW-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic tx_valid, tx_last, tx_nocrc;
  logic [7:0] tx_data;
  logic tx_ready = 1'b0;
  logic mac_underrun = 1'b0, mac_retry_limit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_desc_dma #(.MEM_AW(MEM_AW), .RING_ENTRIES(RING)) dut (
    .clk(clk), .rst(rst), .start_cmd(start_cmd), .halt_cmd(halt_cmd),
    .ring_base(ring_base), .busy(busy), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_nocrc(tx_nocrc), .tx_ready(tx_ready),
    .mac_underrun(mac_underrun), .mac_retry_limit(mac_retry_limit)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int rdy_mode = 0;
  int rdy_ctr = 0;

  // sink readiness changes only at the rising edge
  always @(posedge clk) begin
    rdy_ctr <= rdy_ctr + 1;
    case (rdy_mode)
      0: tx_ready <= 1'b1;
      1: tx_ready <= (rdy_ctr % 3 == 0);
      default: tx_ready <= 1'b0;
    endcase
  end

  logic [7:0] cap_d [0:255];
  bit cap_l [0:255];
  bit cap_n [0:255];
  int cap_cnt = 0;
  logic [7:0] exp_d [0:255];
  bit exp_l [0:255];
  bit exp_n [0:255];
  int exp_cnt = 0;
  logic [31:0] wr_ctrl [0:RING-1];

  always @(negedge clk) begin
    if (!rst && tx_valid && tx_ready && cap_cnt < 256) begin
      cap_d[cap_cnt] = tx_data;
      cap_l[cap_cnt] = tx_last;
      cap_n[cap_cnt] = tx_nocrc;
      cap_cnt = cap_cnt + 1;
    end
  end

  function automatic logic [7:0] pat(input int b);
    return 8'((b * 13 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic hwrite(input int a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = MEM_AW'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input int a, output logic [31:0] d);
    @(negedge clk);
    host_addr = MEM_AW'(a);
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic set_desc(input int i, input int baddr, input int len,
                          input bit eof, input bit nocrc, input bit used);
    logic [31:0] c;
    c = 32'(len & 2047);
    c[15] = eof; c[16] = nocrc; c[30] = (i == RING - 1); c[31] = used;
    wr_ctrl[i] = c;
    hwrite(BASE + 2*i, 32'(baddr));
    hwrite(BASE + 2*i + 1, c);
  endtask

  task automatic clear_cap();
    cap_cnt = 0;
    exp_cnt = 0;
  endtask

  task automatic add_exp(input int baddr, input int len, input bit nocrc, input bit eof);
    for (int k = 0; k < len; k++) begin
      exp_d[exp_cnt] = pat(baddr + k);
      exp_l[exp_cnt] = eof && (k == len - 1);
      exp_n[exp_cnt] = nocrc;
      exp_cnt++;
    end
  endtask

  task automatic compare(input string req);
    int bd, bl, bn;
    bd = -1; bl = -1; bn = -1;
    chk(cap_cnt == exp_cnt, req, "byte count", cap_cnt, exp_cnt);
    for (int k = 0; k < exp_cnt && k < cap_cnt; k++) begin
      if (bd < 0 && cap_d[k] != exp_d[k]) bd = k;
      if (bl < 0 && cap_l[k] != exp_l[k]) bl = k;
      if (bn < 0 && cap_n[k] != exp_n[k]) bn = k;
    end
    chk(bd < 0, req, "byte data (index)", bd, -1);
    chk(bl < 0, "R4", "last flag mismatch (index)", bl, -1);
    chk(bn < 0, "R5", "nocrc flag mismatch (index)", bn, -1);
  endtask

  task automatic start_pulse();
    @(negedge clk); start_cmd = 1'b1;
    @(negedge clk); start_cmd = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    bit seen;
    seen = 0;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (busy) seen = 1;
      else if (seen) break;
    end
    chk(seen && !busy, req, "busy rise then fall", {seen, busy}, 2'b10);
  endtask

  task automatic wait_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) mac_underrun = 1'b1; else if (which == 1) mac_retry_limit = 1'b1; else halt_cmd = 1'b1;
    @(negedge clk);
    mac_underrun = 1'b0; mac_retry_limit = 1'b0; halt_cmd = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int bidx;
    string rq;

    // reset and ring sweep (R1)
    wait_cycles(3);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !tx_valid, "R1", "busy/valid during sweep", {busy, tx_valid}, 0);
    wait_cycles(RING + 4);
    for (int i = 0; i < RING; i++) begin
      hread(BASE + 2*i + 1, d);
      chk(d == ((i == RING - 1) ? 32'hC000_0000 : 32'h8000_0000), "R1", "swept control word", d,
          (i == RING - 1) ? 32'hC000_0000 : 32'h8000_0000);
    end
    for (int w = 32; w < 256; w++)
      hwrite(w, {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});

    // empty ring: start stops at an owned slot (R8)
    clear_cap();
    start_pulse();
    wait_idle("R8");
    wait_cycles(3);
    chk(cap_cnt == 0, "R8", "bytes sent from owned slot", cap_cnt, 0);
    hread(BASE + 1, d);
    chk(d == 32'h8000_0000, "R8", "owned slot unchanged", d, 32'h8000_0000);
    bidx = 0;

    // table of single-descriptor frames (R2 R3 R5 R6 R7)
    for (int i = 0; i < 6; i++) begin
      rdy_mode = i % 2;
      clear_cap();
      set_desc(bidx, int'(VEC[i][23:12]), int'(VEC[i][11:1]), 1'b1, VEC[i][0], 1'b0);
      set_desc((bidx + 1) % RING, 0, 0, 1'b1, 1'b0, 1'b1);
      add_exp(int'(VEC[i][23:12]), int'(VEC[i][11:1]), VEC[i][0], 1'b1);
      start_pulse();
      wait_idle("R2");
      rq = (i == 4) ? "R7" : "R3";
      compare(rq);
      hread(BASE + 2*bidx + 1, d);
      chk(d == (wr_ctrl[bidx] | 32'h8000_0000), "R6", "written-back control", d, wr_ctrl[bidx] | 32'h8000_0000);
      bidx = (bidx + 1) % RING;
    end

    // frame over two descriptors, crossing the wrap slot (R4 R7)
    rdy_mode = 0;
    clear_cap();
    set_desc(2, 300, 6, 1'b0, 1'b0, 1'b0);
    set_desc(3, 400, 5, 1'b1, 1'b0, 1'b0);
    set_desc(0, 0, 0, 1'b1, 1'b0, 1'b1);
    add_exp(300, 6, 1'b0, 1'b0);
    add_exp(400, 5, 1'b0, 1'b1);
    start_pulse();
    wait_idle("R4");
    compare("R4");
    hread(BASE + 5, d);
    chk(d == (wr_ctrl[2] | 32'h8000_0000), "R6", "first part written back", d, wr_ctrl[2] | 32'h8000_0000);
    hread(BASE + 7, d);
    chk(d == (wr_ctrl[3] | 32'h8000_0000), "R7", "wrap slot written back", d, wr_ctrl[3] | 32'h8000_0000);

    // write-back held off while the last byte is stalled (R6 R2)
    rdy_mode = 2;
    clear_cap();
    set_desc(0, 140, 4, 1'b1, 1'b0, 1'b0);
    set_desc(1, 0, 0, 1'b1, 1'b0, 1'b1);
    add_exp(140, 4, 1'b0, 1'b1);
    start_pulse();
    wait_cycles(30);
    chk(busy == 1'b1, "R2", "busy while stalled", busy, 1);
    chk(tx_valid == 1'b1, "R6", "byte waiting", tx_valid, 1);
    hread(BASE + 1, d);
    chk(d[31] == 1'b0, "R6", "used bit before drain", d[31], 0);
    rdy_mode = 0;
    wait_idle("R6");
    compare("R3");
    hread(BASE + 1, d);
    chk(d == (wr_ctrl[0] | 32'h8000_0000), "R6", "used bit after drain", d, wr_ctrl[0] | 32'h8000_0000);

    // MAC underrun then retry limit in consecutive frames (R10)
    for (int j = 0; j < 2; j++) begin
      rdy_mode = 2;
      clear_cap();
      set_desc(1 + j, 160 + 16*j, 6, 1'b1, 1'b0, 1'b0);
      set_desc(2 + j, 0, 0, 1'b1, 1'b0, 1'b1);
      start_pulse();
      wait_cycles(20);
      pulse(j);
      rdy_mode = 0;
      wait_idle("R10");
      hread(BASE + 2*(1 + j) + 1, d);
      chk(d == (wr_ctrl[1 + j] | 32'h8000_0000 | ((j == 0) ? 32'h1000_0000 : 32'h2000_0000)),
          "R10", "error status", d, wr_ctrl[1 + j] | 32'h8000_0000 | ((j == 0) ? 32'h1000_0000 : 32'h2000_0000));
    end

    // frame runs into an owned slot (R9)
    clear_cap();
    set_desc(3, 200, 3, 1'b0, 1'b0, 1'b0);
    set_desc(0, 0, 0, 1'b0, 1'b0, 1'b1);
    add_exp(200, 3, 1'b0, 1'b0);
    start_pulse();
    wait_idle("R9");
    compare("R9");
    hread(BASE + 1, d);
    chk(d == 32'h8800_0000, "R9", "exhausted flag", d, 32'h8800_0000);
    hread(BASE + 7, d);
    chk(d == (wr_ctrl[3] | 32'h8000_0000), "R9", "sent part written back", d, wr_ctrl[3] | 32'h8000_0000);

    // halt in the middle of a frame, then restart (R11)
    rdy_mode = 1;
    clear_cap();
    set_desc(0, 500, 10, 1'b0, 1'b0, 1'b0);
    set_desc(1, 520, 4, 1'b1, 1'b1, 1'b0);
    set_desc(2, 540, 3, 1'b1, 1'b0, 1'b0);
    set_desc(3, 0, 0, 1'b1, 1'b0, 1'b1);
    add_exp(500, 10, 1'b0, 1'b0);
    add_exp(520, 4, 1'b1, 1'b1);
    start_pulse();
    for (int t = 0; t < 500 && cap_cnt < 2; t++) @(negedge clk);
    pulse(2);
    wait_idle("R11");
    wait_cycles(3);
    compare("R11");
    hread(BASE + 5, d);
    chk(d == wr_ctrl[2], "R11", "next slot untouched after halt", d, wr_ctrl[2]);
    clear_cap();
    add_exp(540, 3, 1'b0, 1'b1);
    start_pulse();
    wait_idle("R11");
    compare("R11");
    hread(BASE + 5, d);
    chk(d == (wr_ctrl[2] | 32'h8000_0000), "R11", "slot sent after restart", d, wr_ctrl[2] | 32'h8000_0000);
    chk(!busy && !tx_valid, "R2", "quiet at end", {busy, tx_valid}, 0);

    finish_run();
  end
endmodule